// File: doc/BRIEF.md
# Coprocessor Bus Snoop and Operand Mover

This block rides next to a host processor on a shared bus and picks out the instructions meant for a numeric coprocessor. It watches every host instruction fetch. When the top five bits of the fetched word carry the escape tag, it claims the instruction and keeps the fetch address and the 11-bit opcode for an error handler. Register-form escapes only start the execution unit. Memory-form escapes wait for the host's dummy read: the host computes the operand address and runs the cycle, and this block takes the address from it.

A load takes the dummy-read data as operand word 0. If the operand is longer than one word, the block asks for the bus with a request/grant handshake. It then reads the remaining words in back-to-back cycles, two bytes apart, and hands the bus back with a release pulse. A store ignores the dummy-read data. It waits until the execution unit reports that the result is ready, takes the bus, and writes every word from the latched address upward. The bus is modelled at cycle level. A read by this block returns its data in the same cycle, and a write happens in the cycle that it is shown.

Top module: `snoop_mover`

## Requirements
- R1: A host fetch (hostValid=1, hostFetch=1) is claimed only when hostData[15:11] is 5'b11011. Any other fetch leaves all pointers unchanged and causes no bus activity or execStart.
- R2: When an escape is claimed, instPtr takes the fetch address and opcodeOut takes hostData[10:0]. For a memory form, operPtr takes the address of the next host data read (hostValid=1, hostFetch=0).
- R3: The opcode mode field bits [7:6]=2'b11 marks a register form. execStart pulses in the cycle after the fetch, busy stays low, and no bus cycle follows.
- R4: The operand word count comes from opcode bits [10:8]: 000 gives 1 word; 001 and 010 give 2; 011 and 100 give 4; 101 and 110 give 5; 111 gives 1.
- R5: On a load (opcode bit 5 = 0), ldValid, ldIdx=0 and the dummy-read data appear in the cycle after the dummy read. For a one-word load, execStart pulses in that same cycle and the block goes idle.
- R6: For a load of N>1 words, busReq rises in the cycle after the dummy read and stays high until busGrant is sampled. Words 1..N-1 are then read in back-to-back cycles at operPtr+2k, and each word appears on ldData with ldIdx=k one cycle after its read.
- R7: On a store (opcode bit 5 = 1), the dummy-read data is ignored and execStart pulses in the cycle after the dummy read. After resultReady, the block requests the bus and writes words k=0..N-1 back to back at operPtr+2k, with the data taken from resultWord while wordIdx=k.
- R8: busRelease pulses for one cycle right after the last transferred word, and the block is idle in the next cycle. For a multi-word load, execStart pulses in that next cycle.
- R9: busy is high from the cycle after a memory-form escape until the block returns to idle. Escape fetches seen while busy are not claimed.
- R10: mstRead and mstWrite are never high unless busGrant is high.
- R11: After reset: busy, busReq, busRelease, mstRead, mstWrite, ldValid and execStart are low, and instPtr, operPtr and opcodeOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host bus cycle present this cycle |
| hostFetch | input | 1 | 1 = instruction fetch, 0 = data read |
| hostAddr | input | 20 | Address of the host cycle |
| hostData | input | 16 | Data word on the host cycle |
| resultReady | input | 1 | Store result available from the execution unit |
| resultWord | input | 16 | Result word selected by wordIdx |
| busGrant | input | 1 | Bus granted to this block |
| mstRData | input | 16 | Read data for a cycle run by this block |
| busReq | output | 1 | Bus request |
| busRelease | output | 1 | One-cycle grant-return pulse |
| mstRead | output | 1 | This block reads at mstAddr |
| mstWrite | output | 1 | This block writes mstWData at mstAddr |
| mstAddr | output | 20 | Address of a cycle run by this block |
| mstWData | output | 16 | Write data |
| wordIdx | output | 3 | Current operand word index |
| ldValid | output | 1 | Load word valid toward the execution unit |
| ldIdx | output | 3 | Index of the load word |
| ldData | output | 16 | Load word |
| execStart | output | 1 | Execution start pulse |
| busy | output | 1 | A memory-form transfer is pending |
| instPtr | output | 20 | Saved instruction address |
| operPtr | output | 20 | Saved operand address |
| opcodeOut | output | 11 | Saved opcode |

## Verification
The hardest case to reach is an escape fetch that arrives while a store is parked waiting for its result. The block must neither claim it nor disturb the saved pointers. The stimulus starts a five-word store, withholds resultReady for a few cycles, and issues an escape fetch during that gap. It then completes the store and confirms that the write sequence, the pointers and the event stream are those of the first instruction alone. The grant is delayed by 0, 1 and 3 cycles, so the request is seen both being held and being served at once.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int OPC_W  = 11;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = 5;
  localparam logic [TAG_W-1:0] ESC_TAG = 5'b11011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DUMMY, ST_STWAIT, ST_REQ, ST_READ, ST_WRITE, ST_REL
  } mvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchInst;
    logic latchOper;
    logic capDummy;
    logic setIdx1;
    logic clrIdx;
    logic readWord;
    logic writeWord;
  } mvStrobe_t;

  // decode results from datapath to control
  typedef struct packed {
    logic escNow;
    logic memRefNow;
    logic isStore;
    logic singleWord;
    logic lastWord;
  } mvStatus_t;
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostValid,
  input  logic      hostFetch,
  input  logic      resultReady,
  input  logic      busGrant,
  input  mvStatus_t stat,
  output mvStrobe_t strb,
  output logic      busReq,
  output logic      busRelease,
  output logic      mstRead,
  output logic      mstWrite,
  output logic      execStart,
  output logic      busy
);
  mvState_t state, nextState;
  logic     execNext;
  logic     fetchSeen, readSeen;

  assign fetchSeen = hostValid && hostFetch;
  assign readSeen  = hostValid && !hostFetch;

  always_comb begin
    strb      = '0;
    nextState = state;
    execNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fetchSeen && stat.escNow) begin
          strb.latchInst = 1'b1;
          if (stat.memRefNow) nextState = ST_DUMMY;
          else                execNext  = 1'b1;
        end
      end
      ST_DUMMY: begin
        if (readSeen) begin
          strb.latchOper = 1'b1;
          if (stat.isStore) begin
            strb.clrIdx = 1'b1;
            execNext    = 1'b1;
            nextState   = ST_STWAIT;
          end else begin
            strb.capDummy = 1'b1;
            strb.setIdx1  = 1'b1;
            if (stat.singleWord) begin
              execNext  = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_REQ;
            end
          end
        end
      end
      ST_STWAIT: begin
        if (resultReady) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) nextState = stat.isStore ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        strb.readWord = 1'b1;
        if (stat.lastWord) nextState = ST_REL;
      end
      ST_WRITE: begin
        strb.writeWord = 1'b1;
        if (stat.lastWord) nextState = ST_REL;
      end
      ST_REL: begin
        execNext  = !stat.isStore;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      execStart <= 1'b0;
    end else begin
      state     <= nextState;
      execStart <= execNext;
    end
  end

  assign busReq     = (state == ST_REQ);
  assign mstRead    = (state == ST_READ);
  assign mstWrite   = (state == ST_WRITE);
  assign busRelease = (state == ST_REL);
  assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int OW = OPC_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  input  logic [DW-1:0] mstRData,
  input  logic [DW-1:0] resultWord,
  input  mvStrobe_t     strb,
  output mvStatus_t     stat,
  output logic [AW-1:0] instPtr,
  output logic [AW-1:0] operPtr,
  output logic [OW-1:0] opcodeOut,
  output logic [AW-1:0] mstAddr,
  output logic [DW-1:0] mstWData,
  output logic [IW-1:0] wordIdx,
  output logic          ldValid,
  output logic [IW-1:0] ldIdx,
  output logic [DW-1:0] ldData
);
  localparam int BYTE_SHIFT = $clog2(DW / 8);
  localparam int TYPE_HI    = OW - 1;
  localparam int MODE_HI    = OW - 4;
  localparam int STORE_BIT  = OW - 6;

  logic [IW-1:0] idx;
  logic [IW-1:0] wordCnt;
  logic [2:0]    typeCode;

  // operand length table
  assign typeCode = opcodeOut[TYPE_HI -: 3];
  always_comb begin
    unique case (typeCode)
      3'b000:         wordCnt = IW'(1);
      3'b001, 3'b010: wordCnt = IW'(2);
      3'b011, 3'b100: wordCnt = IW'(4);
      3'b101, 3'b110: wordCnt = IW'(5);
      default:        wordCnt = IW'(1);
    endcase
  end

  assign stat.escNow     = (hostData[DW-1 -: TAG_W] == ESC_TAG);
  assign stat.memRefNow  = (hostData[MODE_HI -: 2] != 2'b11);
  assign stat.isStore    = opcodeOut[STORE_BIT];
  assign stat.singleWord = (wordCnt == IW'(1));
  assign stat.lastWord   = (idx == wordCnt - IW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instPtr   <= '0;
      operPtr   <= '0;
      opcodeOut <= '0;
      idx       <= '0;
      ldValid   <= 1'b0;
      ldIdx     <= '0;
      ldData    <= '0;
    end else begin
      if (strb.latchInst) begin
        instPtr   <= hostAddr;
        opcodeOut <= hostData[OW-1:0];
      end
      if (strb.latchOper) operPtr <= hostAddr;
      if (strb.clrIdx)                         idx <= '0;
      else if (strb.setIdx1)                   idx <= IW'(1);
      else if (strb.readWord || strb.writeWord) idx <= idx + IW'(1);
      ldValid <= strb.capDummy || strb.readWord;
      if (strb.capDummy) begin
        ldIdx  <= '0;
        ldData <= hostData;
      end else if (strb.readWord) begin
        ldIdx  <= idx;
        ldData <= mstRData;
      end
    end
  end

  assign mstAddr  = operPtr + (AW'(idx) << BYTE_SHIFT);
  assign mstWData = strb.writeWord ? resultWord : '0;
  assign wordIdx  = idx;
endmodule

// File: rtl/snoop_mover.sv
module snoop_mover
  import snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostFetch,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              resultReady,
  input  logic [DATA_W-1:0] resultWord,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] mstRData,
  output logic              busReq,
  output logic              busRelease,
  output logic              mstRead,
  output logic              mstWrite,
  output logic [ADDR_W-1:0] mstAddr,
  output logic [DATA_W-1:0] mstWData,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              ldValid,
  output logic [IDX_W-1:0]  ldIdx,
  output logic [DATA_W-1:0] ldData,
  output logic              execStart,
  output logic              busy,
  output logic [ADDR_W-1:0] instPtr,
  output logic [ADDR_W-1:0] operPtr,
  output logic [OPC_W-1:0]  opcodeOut
);
  mvStrobe_t strb;
  mvStatus_t stat;

  snoop_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostFetch(hostFetch),
    .resultReady(resultReady), .busGrant(busGrant), .stat(stat), .strb(strb),
    .busReq(busReq), .busRelease(busRelease), .mstRead(mstRead),
    .mstWrite(mstWrite), .execStart(execStart), .busy(busy)
  );

  snoop_dp #(.AW(ADDR_W), .DW(DATA_W), .OW(OPC_W), .IW(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .mstRData(mstRData), .resultWord(resultWord), .strb(strb), .stat(stat),
    .instPtr(instPtr), .operPtr(operPtr), .opcodeOut(opcodeOut),
    .mstAddr(mstAddr), .mstWData(mstWData), .wordIdx(wordIdx),
    .ldValid(ldValid), .ldIdx(ldIdx), .ldData(ldData)
  );
endmodule

// File: rtl/snoop_mover_chk.sv
module snoop_mover_chk
  import snoop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busGrant,
  input logic              busReq,
  input logic              busRelease,
  input logic              mstRead,
  input logic              mstWrite,
  input logic [ADDR_W-1:0] mstAddr,
  input logic              busy,
  input logic [ADDR_W-1:0] instPtr
);
  // R10
  bus_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstRead || mstWrite) |-> busGrant);
  // R8
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busReq, mstRead, mstWrite, busRelease}));
  // R8
  rel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |=> !busy);
  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstRead && $past(mstRead)) |-> (mstAddr == $past(mstAddr) + ADDR_W'(2)));
  // R7
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstWrite && $past(mstWrite)) |-> (mstAddr == $past(mstAddr) + ADDR_W'(2)));
  // R9
  inst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(instPtr));
endmodule

bind snoop_mover snoop_mover_chk i_chk (
  .clk(clk), .rstN(rstN), .busGrant(busGrant), .busReq(busReq),
  .busRelease(busRelease), .mstRead(mstRead), .mstWrite(mstWrite),
  .mstAddr(mstAddr), .busy(busy), .instPtr(instPtr)
);

// File: tb/test_snoop_mover.sv
module test_snoop_mover;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostFetch = 1'b0;
  logic [19:0] hostAddr = '0;
  logic [15:0] hostData = '0;
  logic        resultReady = 1'b0;
  logic [15:0] resultWord;
  logic        busGrant = 1'b0;
  logic [15:0] mstRData;
  logic        busReq, busRelease, mstRead, mstWrite;
  logic [19:0] mstAddr;
  logic [15:0] mstWData;
  logic [2:0]  wordIdx;
  logic        ldValid;
  logic [2:0]  ldIdx;
  logic [15:0] ldData;
  logic        execStart, busy;
  logic [19:0] instPtr, operPtr;
  logic [10:0] opcodeOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_mover i_snoop_mover (.*);

  typedef enum int {EV_LD, EV_RD, EV_WR, EV_REL, EV_EXEC} evKind_t;
  typedef struct {
    evKind_t     kind;
    logic [19:0] addr;
    logic [15:0] data;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int nCmp = 0, nBad = 0, grantDelay = 0, gCnt = 0;
  bit finished = 0;
  logic [15:0] mem [64];

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h5000 ^ 16'(i * 311);
  assign mstRData   = mem[mstAddr[6:1]];
  assign resultWord = 16'hC0F0 + 16'(wordIdx) * 16'h0111;

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic void push(evKind_t k, logic [19:0] a, logic [15:0] d, string r);
    expItem_t it;
    it.kind = k; it.addr = a; it.data = d; it.req = r;
    expQ.push_back(it);
  endfunction

  function automatic void popCmp(evKind_t k, logic [19:0] a, logic [15:0] d);
    expItem_t it;
    if (expQ.size() == 0) begin
      chk(0, "R1", "unexpected event kind", k, -1);
      return;
    end
    it = expQ.pop_front();
    chk(it.kind == k, it.req, "event kind", k, it.kind);
    if (k == EV_LD || k == EV_RD || k == EV_WR)
      chk(it.addr == a, it.req, "event addr/idx", a, it.addr);
    if (k == EV_LD || k == EV_WR)
      chk(it.data == d, it.req, "event data", d, it.data);
  endfunction

  // monitor: scoreboard consumer
  always @(negedge clk) if (rstN && !finished) begin
    if (ldValid)    popCmp(EV_LD, 20'(ldIdx), ldData);
    if (mstRead)    popCmp(EV_RD, mstAddr, 16'h0);
    if (mstWrite)   popCmp(EV_WR, mstAddr, mstWData);
    if (busRelease) popCmp(EV_REL, 20'h0, 16'h0);
    if (execStart)  popCmp(EV_EXEC, 20'h0, 16'h0);
  end

  // bus arbiter model
  always @(negedge clk) begin
    if (busRelease) begin
      busGrant = 1'b0; gCnt = 0;
    end else if (busReq && !busGrant) begin
      if (gCnt >= grantDelay) begin busGrant = 1'b1; gCnt = 0; end
      else gCnt++;
    end
  end

  function automatic int expWords(logic [2:0] t);
    case (t)
      3'b000: return 1;
      3'b001, 3'b010: return 2;
      3'b011, 3'b100: return 4;
      3'b101, 3'b110: return 5;
      default: return 1;
    endcase
  endfunction

  task automatic runInstr(input logic [19:0] fAddr, input logic [10:0] opc,
                          input logic [19:0] oAddr, input logic [15:0] dummy,
                          input int gDly, input bit injectEsc, input string req);
    bit nonMem = (opc[7:6] == 2'b11);
    bit isSt   = opc[5];
    int n      = expWords(opc[10:8]);
    grantDelay = gDly;
    if (nonMem) push(EV_EXEC, 0, 0, "R3");
    else if (isSt) begin
      push(EV_EXEC, 0, 0, "R7");
      for (int k = 0; k < n; k++)
        push(EV_WR, oAddr + 20'(2*k), 16'hC0F0 + 16'(k) * 16'h0111, req);
      push(EV_REL, 0, 0, "R8");
    end else begin
      push(EV_LD, 0, dummy, "R5");
      if (n == 1) push(EV_EXEC, 0, 0, "R5");
      else begin
        for (int k = 1; k < n; k++) begin
          push(EV_RD, oAddr + 20'(2*k), 0, req);
          push(EV_LD, 20'(k), mem[6'((oAddr >> 1) + 20'(k))], req);
        end
        push(EV_REL, 0, 0, "R8");
        push(EV_EXEC, 0, 0, "R8");
      end
    end
    @(posedge clk); #1;
    hostValid = 1; hostFetch = 1; hostAddr = fAddr; hostData = {5'b11011, opc};
    @(posedge clk); #1;
    hostValid = 0;
    if (nonMem) chk(busy == 0, "R3", "busy after register form", busy, 0);
    else begin
      chk(busy == 1, "R9", "busy after memory escape", busy, 1);
      @(posedge clk); #1;
      hostValid = 1; hostFetch = 0; hostAddr = oAddr; hostData = dummy;
      @(posedge clk); #1;
      hostValid = 0;
      if (isSt) begin
        @(posedge clk); #1;
        if (injectEsc) begin
          hostValid = 1; hostFetch = 1; hostAddr = 20'hFFFF0; hostData = {5'b11011, 11'h0C4};
          @(posedge clk); #1;
          hostValid = 0;
        end
        @(posedge clk); #1;
        chk(busy == 1 && busReq == 0, "R7", "store waits for result", {busy, busReq}, 2'b10);
        resultReady = 1;
        @(posedge clk); #1;
        resultReady = 0;
      end
    end
    for (int k = 0; k < 60 && busy; k++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk(expQ.size() == 0, req, "pending expected events", expQ.size(), 0);
    expQ.delete();
    chk(instPtr == fAddr, "R2", "instPtr", instPtr, fAddr);
    chk(opcodeOut == opc, "R2", "opcodeOut", opcodeOut, opc);
    if (!nonMem) chk(operPtr == oAddr, "R2", "operPtr", operPtr, oAddr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R8", "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk({busy, busReq, busRelease, mstRead, mstWrite, ldValid, execStart} == 0,
        "R11", "control outputs after reset",
        {busy, busReq, busRelease, mstRead, mstWrite, ldValid, execStart}, 0);
    chk(instPtr == 0 && operPtr == 0 && opcodeOut == 0, "R11", "pointers after reset",
        {instPtr, operPtr}, 0);

    // R1 non-escape fetch is not claimed
    @(posedge clk); #1;
    hostValid = 1; hostFetch = 1; hostAddr = 20'h55550; hostData = 16'h8B12;
    @(posedge clk); #1;
    hostValid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(instPtr == 0 && busy == 0, "R1", "non-escape fetch ignored", instPtr, 0);

    // R3 register form
    runInstr(20'h12340, {3'b000, 2'b11, 6'h05}, 20'h0, 16'h0, 0, 0, "R3");
    // R4 R5 one-word load (type 000)
    runInstr(20'h20010, {3'b000, 2'b01, 1'b0, 5'h03}, 20'h00A00, 16'h1234, 0, 0, "R5");
    // R4 R6 two-word load (type 001), immediate grant
    runInstr(20'h20020, {3'b001, 2'b00, 1'b0, 5'h00}, 20'h00A10, 16'h2222, 0, 0, "R6");
    // R4 R6 four-word load (type 011), grant held off
    runInstr(20'h20030, {3'b011, 2'b10, 1'b0, 5'h11}, 20'h00B04, 16'h3333, 3, 0, "R6");
    // R4 R6 five-word load (BCD type 110)
    runInstr(20'h20040, {3'b110, 2'b00, 1'b0, 5'h07}, 20'h00C20, 16'h4444, 1, 0, "R6");
    // R4 reserved type 111 acts as one word
    runInstr(20'h20050, {3'b111, 2'b01, 1'b0, 5'h01}, 20'h00C80, 16'h5555, 0, 0, "R4");
    // R7 R9 five-word store with escape injected while waiting
    runInstr(20'h30000, {3'b101, 2'b00, 1'b1, 5'h02}, 20'h04000, 16'hDEAD, 1, 1, "R7");
    // R7 one-word store (type 000)
    runInstr(20'h30010, {3'b000, 2'b10, 1'b1, 5'h00}, 20'h04100, 16'hBEEF, 0, 0, "R7");
    // R7 R4 two-word store (type 010)
    runInstr(20'h30020, {3'b010, 2'b01, 1'b1, 5'h1F}, 20'h04200, 16'hF00D, 2, 0, "R7");
    // R4 four-word store (type 100)
    runInstr(20'h30030, {3'b100, 2'b00, 1'b1, 5'h04}, 20'h04300, 16'h0BAD, 0, 0, "R4");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule